// File: doc/BRIEF.md
# Multi-Function L2 Unicast Forwarding Switch

This block makes the forwarding decision for a five-port layer-2 switch that joins one physical link to four physical functions. There is one instance per physical link. For each frame it is given the destination MAC and the port the frame came in on, and it returns a five-bit port mask naming every port the frame must leave on. Frame storage, MAC/PHY logic, VLAN handling and error checking live elsewhere.

Unicast steering is not learned. Each function explicitly asks for a unicast MAC to be delivered to itself with a table-write command, and these requests fill a small content-addressable table of valid/MAC/owner entries. Group-addressed frames, meaning multicast and broadcast, skip the table and are flooded to the functions. A frame never leaves on the port it arrived on. The lookup result is registered and handed over through a valid/ready handshake.

Top module: `l2sw_top`

## Requirements
- R1: After reset the result output is not valid, the error flag is low, the lookup input is ready, and the table holds no entries.
- R2: A unicast destination (bit 40 of the 48-bit MAC is 0) that matches a table entry yields a mask with exactly one bit set: the owner function's bit. Functions 0..3 use mask bits 0..3, and the link uses mask bit 4.
- R3: If the matched owner is the frame's own ingress function, the mask is all zero. The ingress codes are 0..3 for the functions and 4 for the link.
- R4: A unicast miss arriving from a function yields mask 5'b10000 (link only).
- R5: A unicast miss arriving from the link yields an all-zero mask.
- R6: A group destination (bit 40 = 1, including broadcast) yields all four function bits except the ingress function's bit. The link bit is never set for such a frame.
- R7: Writing a MAC that is already in the table replaces its owner and uses no new entry. The table never holds two valid entries with the same MAC.
- R8: Writing a new MAC while every entry is valid raises the error output for exactly one cycle, and the table is left unchanged.
- R9: A lookup is accepted when valid and ready are both high. Its result is valid on the next cycle. While the result is held off, it stays valid and unchanged and the lookup input is not ready. A lookup sees the table as it stood before any write made in the same cycle.
- R10: The table holds 2**TBL_LOG2 entries. TBL_LOG2 is a 5-bit log2 size with a default of 3, which gives 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request valid |
| lkp_ready_o | output | 1 | Lookup request accepted |
| lkp_mac_i | input | 48 | Destination MAC |
| lkp_src_i | input | 3 | Ingress port: 0..3 are functions, 4 is the link |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumed |
| res_mask_o | output | 5 | Egress mask: bits 3..0 are functions, bit 4 is the link |
| cmd_valid_i | input | 1 | Table write strobe |
| cmd_fn_i | input | 2 | Requesting function, which becomes the owner |
| cmd_mac_i | input | 48 | Unicast MAC to steer |
| cmd_err_o | output | 1 | One-cycle pulse: a write was rejected because the table was full |

## Verification
The bench targets the ingress exclusion for both table hits and floods. A design that got this wrong would reflect frames back to their sender. It targets the two miss directions: a swapped default either drops function traffic or leaks link traffic back to the link. It fills the table to capacity and then writes an existing MAC and a new MAC. A wrong design would report a false error on the overwrite, or would overwrite a live entry instead of rejecting the new one. It also holds off a result. A faulty handshake would then lose the result or replace it while it is stalled.

// File: rtl/l2sw_pkg.sv
package l2sw_pkg;
  localparam int unsigned NUM_FN  = 4;
  localparam int unsigned NUM_PRT = NUM_FN + 1;
  localparam int unsigned FN_W    = $clog2(NUM_FN);
  localparam int unsigned SRC_W   = $clog2(NUM_PRT);
  localparam int unsigned LINK_BIT = NUM_FN;
  localparam int unsigned GRP_BIT  = 40;
  typedef logic [NUM_PRT-1:0] mask_t;
endpackage

// File: rtl/l2sw_cam.sv
module l2sw_cam
  import l2sw_pkg::*;
#(
  parameter int unsigned TBL_LOG2 = 3,
  parameter int unsigned MAC_W    = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [MAC_W-1:0] wr_mac_i,
  input  logic [FN_W-1:0]  wr_fn_i,
  output logic             wr_reject_o,
  input  logic [MAC_W-1:0] lk_mac_i,
  output logic             lk_hit_o,
  output logic [FN_W-1:0]  lk_fn_o
);
  localparam int unsigned DEPTH = 1 << TBL_LOG2;
  localparam int unsigned IDX_W = (TBL_LOG2 > 0) ? TBL_LOG2 : 1;

  logic [DEPTH-1:0] vld_q;
  logic [MAC_W-1:0] mac_q [DEPTH];
  logic [FN_W-1:0]  fn_q  [DEPTH];
  logic [DEPTH-1:0] lk_match, wr_match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign lk_match[g] = vld_q[g] && (mac_q[g] == lk_mac_i);
    assign wr_match[g] = vld_q[g] && (mac_q[g] == wr_mac_i);
  end

  always_comb begin
    lk_fn_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (lk_match[i]) lk_fn_o = lk_fn_o | fn_q[i];
  end
  assign lk_hit_o = |lk_match;

  logic             wr_hit, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx, tgt_idx;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (wr_match[i]) hit_idx  = IDX_W'(i);
      if (!vld_q[i])   free_idx = IDX_W'(i);
    end
  end
  assign wr_hit      = |wr_match;
  assign free_any    = ~&vld_q;
  assign tgt_idx     = wr_hit ? hit_idx : free_idx;
  assign wr_reject_o = wr_en_i && !wr_hit && !free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mac_q[i] <= '0;
        fn_q[i]  <= '0;
      end
    end else if (wr_en_i && (wr_hit || free_any)) begin
      vld_q[tgt_idx] <= 1'b1;
      mac_q[tgt_idx] <= wr_mac_i;
      fn_q[tgt_idx]  <= wr_fn_i;
    end
  end

  AST_UNIQUE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R7
  AST_FULL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reject_o |=> $stable(vld_q) && (&vld_q)); // R8
endmodule

// File: rtl/l2sw_decide.sv
module l2sw_decide
  import l2sw_pkg::*;
#(
  parameter int unsigned MAC_W = 48
) (
  input  logic [MAC_W-1:0] mac_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             hit_i,
  input  logic [FN_W-1:0]  hit_fn_i,
  output mask_t            mask_o
);
  logic from_link, is_grp;
  assign from_link = (src_i >= SRC_W'(NUM_FN));
  assign is_grp    = mac_i[GRP_BIT];

  always_comb begin
    mask_o = '0;
    if (is_grp) begin
      mask_o[NUM_FN-1:0] = '1;
      if (!from_link) mask_o[src_i[FN_W-1:0]] = 1'b0;
    end else if (hit_i) begin
      if (from_link || (hit_fn_i != src_i[FN_W-1:0])) mask_o[hit_fn_i] = 1'b1;
    end else if (!from_link) begin
      mask_o[LINK_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/l2sw_top.sv
module l2sw_top
  import l2sw_pkg::*;
#(
  parameter int unsigned TBL_LOG2 = 3,  // 5-bit log2 size field
  parameter int unsigned MAC_W    = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  output logic             lkp_ready_o,
  input  logic [47:0]      lkp_mac_i,
  input  logic [2:0]       lkp_src_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [4:0]       res_mask_o,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_fn_i,
  input  logic [47:0]      cmd_mac_i,
  output logic             cmd_err_o
);
  logic            hit, reject;
  logic [FN_W-1:0] hit_fn;
  mask_t           mask_d, mask_q;
  logic            vld_q, err_q, grp_q;
  logic [SRC_W-1:0] src_q;
  logic            accept;

  l2sw_cam #(.TBL_LOG2(TBL_LOG2), .MAC_W(MAC_W)) u_cam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cmd_valid_i),
    .wr_mac_i    (cmd_mac_i),
    .wr_fn_i     (cmd_fn_i),
    .wr_reject_o (reject),
    .lk_mac_i    (lkp_mac_i),
    .lk_hit_o    (hit),
    .lk_fn_o     (hit_fn)
  );

  l2sw_decide #(.MAC_W(MAC_W)) u_decide (
    .mac_i    (lkp_mac_i),
    .src_i    (lkp_src_i),
    .hit_i    (hit),
    .hit_fn_i (hit_fn),
    .mask_o   (mask_d)
  );

  assign lkp_ready_o = !vld_q || res_ready_i;
  assign accept      = lkp_valid_i && lkp_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
      src_q  <= '0;
      grp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept) begin
        vld_q  <= 1'b1;
        mask_q <= mask_d;
        src_q  <= lkp_src_i;
        grp_q  <= lkp_mac_i[GRP_BIT];
      end else if (res_ready_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign res_valid_o = vld_q;
  assign res_mask_o  = mask_q;
  assign cmd_err_o   = err_q;

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_mask_o)); // R9
  AST_NO_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && (src_q < SRC_W'(NUM_FN)) |-> !res_mask_o[src_q[FN_W-1:0]]); // R3
  AST_GRP_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && grp_q |-> !res_mask_o[LINK_BIT]); // R6
  AST_UC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !grp_q |-> $onehot0(res_mask_o)); // R2
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o && !$past(cmd_valid_i) |-> 1'b0); // R8
endmodule

// File: tb/l2sw_top_test.sv
module l2sw_top_test;
  localparam int DEPTH = 8;  // R10: 2**TBL_LOG2 with TBL_LOG2 = 3

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0, lkp_ready, res_valid, res_ready = 1'b1;
  logic [47:0] lkp_mac = '0, cmd_mac = '0;
  logic [2:0]  lkp_src = '0;
  logic [4:0]  res_mask;
  logic        cmd_valid = 1'b0, cmd_err;
  logic [1:0]  cmd_fn = '0;

  int checks = 0, errors = 0;
  logic        m_vld [DEPTH];
  logic [47:0] m_mac [DEPTH];
  logic [1:0]  m_fn  [DEPTH];

  always #4 clk = ~clk;

  l2sw_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_ready_o(lkp_ready), .lkp_mac_i(lkp_mac), .lkp_src_i(lkp_src),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_mask_o(res_mask),
    .cmd_valid_i(cmd_valid), .cmd_fn_i(cmd_fn), .cmd_mac_i(cmd_mac), .cmd_err_o(cmd_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] uc(input int k);
    return {8'h02, 32'h0, 8'(k)};
  endfunction

  function automatic logic [4:0] exp_mask(input logic [47:0] mac, input logic [2:0] src);
    logic [4:0] m = '0;
    if (mac[40]) begin
      m = 5'b01111;
      if (src < 4) m[src[1:0]] = 1'b0;
      return m;
    end
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_mac[i] == mac) begin
        if (src >= 4 || m_fn[i] != src[1:0]) m[m_fn[i]] = 1'b1;
        return m;
      end
    return (src < 4) ? 5'b10000 : 5'b00000;
  endfunction

  function automatic logic model_write(input logic [47:0] mac, input logic [1:0] fn);
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_mac[i] == mac) begin m_fn[i] = fn; return 1'b0; end
    for (int i = 0; i < DEPTH; i++)
      if (!m_vld[i]) begin m_vld[i] = 1'b1; m_mac[i] = mac; m_fn[i] = fn; return 1'b0; end
    return 1'b1;
  endfunction

  task automatic lookup(input string req, input logic [47:0] mac, input logic [2:0] src);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_mac = mac; lkp_src = src;
    @(negedge clk);
    lkp_valid = 1'b0;
    check({req, " valid"}, 32'(res_valid), 32'd1);
    check({req, " mask"}, 32'(res_mask), 32'(exp_mask(mac, src)));
  endtask

  task automatic write(input string req, input logic [47:0] mac, input logic [1:0] fn);
    logic e;
    e = model_write(mac, fn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mac = mac; cmd_fn = fn;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " err"}, 32'(cmd_err), 32'(e));
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] held;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 1'b0; m_mac[i] = '0; m_fn[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 err", 32'(cmd_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", 32'(lkp_ready), 32'd1);
    lookup("R1 R4 empty miss from fn", uc(1), 3'd0);
    lookup("R5 miss from link", uc(1), 3'd4);
    write("R2 install", uc(1), 2'd2);
    lookup("R2 hit from link", uc(1), 3'd4);
    lookup("R2 hit from fn1", uc(1), 3'd1);
    lookup("R3 hit own ingress", uc(1), 3'd2);
    write("R7 overwrite", uc(1), 2'd3);
    lookup("R7 new owner", uc(1), 3'd4);
    lookup("R6 mc from fn1", 48'h01005e000001, 3'd1);
    lookup("R6 mc from link", 48'h01005e000001, 3'd4);
    lookup("R6 bcast from fn3", 48'hffffffffffff, 3'd3);
    for (int k = 2; k <= DEPTH; k++) write("R10 fill", uc(k), 2'(k));
    write("R8 R10 full reject", uc(20), 2'd1);
    lookup("R8 rejected absent", uc(20), 3'd4);
    lookup("R8 old kept", uc(5), 3'd4);
    write("R7 overwrite when full", uc(2), 2'd0);
    lookup("R7 full overwrite owner", uc(2), 3'd4);
    // R9 backpressure
    @(negedge clk);
    res_ready = 1'b0; lkp_valid = 1'b1; lkp_mac = uc(3); lkp_src = 3'd4;
    held = exp_mask(uc(3), 3'd4);
    @(negedge clk);
    lkp_mac = uc(1);
    check("R9 valid", 32'(res_valid), 32'd1);
    check("R9 not ready", 32'(lkp_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R9 held mask", 32'(res_mask), 32'(held));
    res_ready = 1'b1;
    @(negedge clk);
    lkp_valid = 1'b0;
    check("R9 next mask", 32'(res_mask), 32'(exp_mask(uc(1), 3'd4)));
    @(negedge clk);
    check("R9 drained", 32'(res_valid), 32'd0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 9));
      logic [47:0] mac = (r == 0) ? {8'h01, 40'($urandom)} : uc(int'($urandom_range(1, 12)));
      if (r < 3 && !mac[40]) write("R7 R8 rand write", mac, 2'($urandom_range(0, 3)));
      else lookup("R2 R6 rand lookup", mac, 3'($urandom_range(0, 4)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule